// File: doc/BRIEF.md
# Windowed PID Scheduler-Share Controller

This block closes a feedback loop around a hardware thread's share of a fixed-length scheduling window. A pulse is given at the start of each window, together with two values: the number of cycles in which the controlled thread actually retired work during the window that just ended, and the share the thread is meant to get. On each pulse the block takes the difference between the target and the measurement. It keeps the ten most recent differences in a small ring store. From that store it derives three values: a moving sum over the last ten windows, a slope term, and a running integral.

Each value is weighted by a signed fixed-point gain. The weighted terms are combined and then limited to a legal share between 0 and 100. The result goes to the scheduler as its new allocation for the thread, and `out_valid` marks the cycle in which a fresh share appears. The slope is the newest difference minus the one leaving the ring, which is the change of the moving sum. The integral adds the moving sum once per window and saturates instead of wrapping.

Window pulses must be at least four cycles apart. The gains must stay steady from a pulse until its `out_valid`.

Top module: `pid_share_ctrl`

## Requirements
- R1: After reset, `share_out` is 0 and `out_valid` is 0. The difference history, the moving sum and the integral all start at zero, so the first window's terms use only its own difference.
- R2: `out_valid` is high for exactly one cycle, four clock edges after the edge that samples `win_start` high. It is low at all other times.
- R3: The per-window difference is `ref_share - meas_cnt`, taken as a signed value.
- R4: The moving sum W equals the sum of the differences of the last ten windows, counting the current one. Windows not yet seen since reset count as zero.
- R5: The slope D equals the current difference minus the difference from ten windows earlier, which is zero if that window has not occurred since reset.
- R6: The integral I adds W once per window. It saturates at +(2^23-1) and -(2^23-1) and never wraps.
- R7: The share is (kp*W + ki*I + kd*D) shifted right arithmetically by 8. The gains are signed Q8.8, so 256 means 1.0. Results below 0 become 0, and results above 100 become 100.
- R8: `share_out` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | One-cycle pulse marking a scheduling window boundary |
| meas_cnt | input | 8 | Active cycles of the controlled thread in the past window |
| ref_share | input | 8 | Target share (set-point) |
| kp | input | 16 | Proportional gain, signed Q8.8 |
| ki | input | 16 | Integral gain, signed Q8.8 |
| kd | input | 16 | Slope gain, signed Q8.8 |
| share_out | output | 7 | New scheduler share, 0..100 |
| out_valid | output | 1 | One-cycle strobe for a fresh `share_out` |

## Verification
The hardest state to reach is the integral sitting at its saturation limit, because the moving sum adds at most about 2550 per window. The stimulus holds the largest positive difference for some 3400 windows with only a tiny integral gain active. It then reverses the sign of the difference: a correct design stays pinned at the top share, while a wrapping accumulator would swing the output to zero. The eviction path is reached by running long random sequences with only the proportional gain set, and then with only the slope gain set, so each term is seen alone once the ring has wrapped.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int unsigned PSC_LATENCY = 4;

  function automatic longint sat_sym(input longint v, input longint lim);
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction
endpackage

// File: rtl/psc_err_ring.sv
module psc_err_ring #(
  parameter int DEPTH = 10,
  parameter int W     = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] evicted
);
  localparam int PW = $clog2(DEPTH);

  logic signed [W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]    filled;
  logic [PW-1:0]       ptr;
  logic signed [W-1:0] rd_q;
  logic                rd_filled;

  // storage without reset: read-first single port, RAM-friendly
  always_ff @(posedge clk) begin
    if (push) begin
      rd_q     <= mem[ptr];
      mem[ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      filled    <= '0;
      rd_filled <= 1'b0;
    end else if (push) begin
      rd_filled   <= filled[ptr];
      filled[ptr] <= 1'b1;
      ptr         <= (ptr == PW'(DEPTH-1)) ? '0 : ptr + 1'b1;
    end
  end

  assign evicted = rd_filled ? rd_q : '0;

  p_ptr_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr < PW'(DEPTH));
  p_fresh_slot_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_filled |-> evicted == '0);
endmodule

// File: rtl/psc_accum.sv
module psc_accum
  import psc_pkg::*;
#(
  parameter int ERR_W = 9,
  parameter int SUM_W = 13,
  parameter int INT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_vld,
  input  logic signed [ERR_W-1:0] err,
  input  logic signed [ERR_W-1:0] evicted,
  output logic signed [SUM_W-1:0] wsum,
  output logic signed [ERR_W:0]   delta,
  output logic signed [INT_W-1:0] integ,
  output logic                    s3_vld
);
  localparam longint IMAX = (longint'(1) <<< (INT_W-1)) - 1;

  logic   s2_vld;
  longint integ_next;

  always_comb begin
    integ_next = sat_sym(longint'(integ) + longint'(wsum), IMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsum   <= '0;
      delta  <= '0;
      integ  <= '0;
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
      if (s1_vld) begin
        wsum  <= wsum + SUM_W'(err) - SUM_W'(evicted);
        delta <= (ERR_W+1)'(err) - (ERR_W+1)'(evicted);
      end
      if (s2_vld) integ <= INT_W'(integ_next);
    end
  end

  p_integ_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && wsum >= 0) |=> integ >= $past(integ));
  p_integ_no_wrap_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && wsum <= 0) |=> integ <= $past(integ));
  p_sums_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> $stable(wsum));
endmodule

// File: rtl/psc_mix.sv
module psc_mix #(
  parameter int GAIN_W  = 16,
  parameter int SUM_W   = 13,
  parameter int DW      = 10,
  parameter int INT_W   = 24,
  parameter int FRAC    = 8,
  parameter int OUT_W   = 7,
  parameter int OUT_MAX = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s3_vld,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic signed [SUM_W-1:0]  wsum,
  input  logic signed [DW-1:0]     delta,
  input  logic signed [INT_W-1:0]  integ,
  output logic [OUT_W-1:0]         share,
  output logic                     out_valid
);
  localparam int ACC_W = GAIN_W + INT_W + 3;

  logic signed [ACC_W-1:0] acc, scaled;
  logic [OUT_W-1:0]        lim;

  always_comb begin
    acc = ACC_W'(kp) * ACC_W'(wsum)
        + ACC_W'(ki) * ACC_W'(integ)
        + ACC_W'(kd) * ACC_W'(delta);
    scaled = acc >>> FRAC;
    if (scaled < 0)                       lim = '0;
    else if (scaled > ACC_W'(OUT_MAX))    lim = OUT_W'(OUT_MAX);
    else                                  lim = OUT_W'(scaled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      share     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= s3_vld;
      if (s3_vld) share <= lim;
    end
  end

  p_share_limit_r7: assert property (@(posedge clk) disable iff (rst)
    share <= OUT_W'(OUT_MAX));
  p_share_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(share));
endmodule

// File: rtl/pid_share_ctrl.sv
module pid_share_ctrl #(
  parameter int CNT_W   = 8,
  parameter int DEPTH   = 10,
  parameter int GAIN_W  = 16,
  parameter int INT_W   = 24,
  parameter int FRAC    = 8,
  parameter int OUT_W   = 7,
  parameter int OUT_MAX = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_start,
  input  logic [CNT_W-1:0]  meas_cnt,
  input  logic [CNT_W-1:0]  ref_share,
  input  logic [GAIN_W-1:0] kp,
  input  logic [GAIN_W-1:0] ki,
  input  logic [GAIN_W-1:0] kd,
  output logic [OUT_W-1:0]  share_out,
  output logic              out_valid
);
  localparam int ERR_W = CNT_W + 1;
  localparam int SUM_W = ERR_W + $clog2(DEPTH) + 1;

  logic signed [ERR_W-1:0] err_now, err_q, evicted;
  logic                    s1_vld, s3_vld;
  logic signed [SUM_W-1:0] wsum;
  logic signed [ERR_W:0]   delta;
  logic signed [INT_W-1:0] integ;

  assign err_now = $signed({1'b0, ref_share}) - $signed({1'b0, meas_cnt});

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= win_start;
      if (win_start) err_q <= err_now;
    end
  end

  psc_err_ring #(.DEPTH(DEPTH), .W(ERR_W)) u_ring (
    .clk(clk), .rst(rst), .push(win_start), .din(err_now), .evicted(evicted)
  );

  psc_accum #(.ERR_W(ERR_W), .SUM_W(SUM_W), .INT_W(INT_W)) u_accum (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .err(err_q), .evicted(evicted),
    .wsum(wsum), .delta(delta), .integ(integ), .s3_vld(s3_vld)
  );

  psc_mix #(.GAIN_W(GAIN_W), .SUM_W(SUM_W), .DW(ERR_W+1), .INT_W(INT_W),
            .FRAC(FRAC), .OUT_W(OUT_W), .OUT_MAX(OUT_MAX)) u_mix (
    .clk(clk), .rst(rst), .s3_vld(s3_vld),
    .kp($signed(kp)), .ki($signed(ki)), .kd($signed(kd)),
    .wsum(wsum), .delta(delta), .integ(integ),
    .share(share_out), .out_valid(out_valid)
  );

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(win_start, 4));
  p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: tb/pid_share_ctrl_bench.sv
module pid_share_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint IMAX = (longint'(1) <<< 23) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        win_start = 1'b0;
  logic [7:0]  meas_cnt = '0, ref_share = '0;
  logic [15:0] kp = '0, ki = '0, kd = '0;
  logic [6:0]  share_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  // bench model state
  int     m_hist [10];
  int     m_ptr;
  longint m_wsum, m_integ;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_share_ctrl u_pid_share_ctrl (
    .clk(clk), .rst(rst), .win_start(win_start), .meas_cnt(meas_cnt),
    .ref_share(ref_share), .kp(kp), .ki(ki), .kd(kd),
    .share_out(share_out), .out_valid(out_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 10; i++) m_hist[i] = 0;
    m_ptr = 0; m_wsum = 0; m_integ = 0;
  endfunction

  function automatic int model_step(input int r, input int m,
                                    input int gp, input int gi, input int gd);
    int e, old, res;
    longint acc, sh;
    e = r - m;                       // R3
    old = m_hist[m_ptr];
    m_hist[m_ptr] = e;
    m_ptr = (m_ptr + 1) % 10;
    m_wsum += e - old;               // R4
    m_integ += m_wsum;               // R6
    if (m_integ > IMAX) m_integ = IMAX;
    if (m_integ < -IMAX) m_integ = -IMAX;
    acc = longint'(gp) * m_wsum + longint'(gi) * m_integ + longint'(gd) * (e - old); // R5
    sh = acc >>> 8;                  // R7
    if (sh < 0) res = 0;
    else if (sh > 100) res = 100;
    else res = int'(sh);
    return res;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; win_start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 share after reset", share_out, 0);
    check("R1 valid after reset", out_valid, 0);
  endtask

  task automatic window(input string req, input int r, input int m,
                        input int gp, input int gi, input int gd);
    int exp, prev;
    @(negedge clk);
    prev = share_out;
    win_start = 1'b1; ref_share = 8'(r); meas_cnt = 8'(m);
    kp = 16'(gp); ki = 16'(gi); kd = 16'(gd);
    exp = model_step(r, m, gp, gi, gd);
    @(negedge clk); win_start = 1'b0;
    check("R2 no early valid", out_valid, 0);
    check("R8 share held", share_out, prev);
    @(negedge clk); @(negedge clk);
    check("R2 no early valid", out_valid, 0);
    @(negedge clk);
    check("R2 valid strobe", out_valid, 1);
    check(req, share_out, exp);
    @(negedge clk);
    check("R2 single cycle", out_valid, 0);
    check("R8 share held", share_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R1 R3: first window sees empty history, kp = 1.0
    window("R1 R3 first window", 40, 10, 256, 0, 0);
    window("R3 negative error clamps", 5, 90, 256, 0, 0);
    // R4: proportional only, past the ring wrap
    for (int i = 0; i < 30; i++)
      window("R4 moving sum", int'($urandom % 101), int'($urandom % 101),
             int'($urandom % 64), 0, 0);
    // R5: slope only
    for (int i = 0; i < 25; i++)
      window("R5 slope", int'($urandom % 256), int'($urandom % 256),
             0, 0, int'($urandom % 200));
    // R7: mixed signed gains
    for (int i = 0; i < 40; i++)
      window("R7 mixed", int'($urandom % 256), int'($urandom % 256),
             int'($urandom % 1025) - 512, int'($urandom % 33) - 16,
             int'($urandom % 1025) - 512);
    for (int i = 0; i < 3; i++) window("R7 lower clamp", 0, 100, 256, 0, 0);
    for (int i = 0; i < 3; i++) window("R7 upper clamp", 255, 0, 512, 0, 0);
    // R6: drive integral into saturation, then reverse the error
    do_reset();
    for (int i = 0; i < 3400; i++) window("R6 integral climb", 255, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) window("R6 saturated hold", 0, 255, 0, 1, 0);
    do_reset();
    for (int i = 0; i < 3400; i++) window("R6 integral fall", 0, 255, 0, -1, 0);
    for (int i = 0; i < 5; i++) window("R6 negative saturation", 255, 0, 0, -1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule